// File: doc/BRIEF.md
# Interrupt Mask and Master-Enable Unit

This block keeps the interrupt mask of a small controller that has six interrupt request lines. The mask is one 8-bit register. Six of its bits enable one request line each. One bit is a global master enable. The remaining bit switches RAM protection on, and it exists only when that option is built in. Software reaches the register through a plain read/write port that decodes a single fixed register address. Reads are combinational.

The master enable is also driven by four single-cycle strobes from the processor core. Two of them set and clear it on software command. A third clears it when an interrupt is taken. The fourth sets it again when the service routine returns. The block masks the six pending request inputs and drives the gated lines, together with one flag that is high when any gated line is active.

Software should change the mask only while the master enable is clear. The block does not block a write made while it is set. It performs the write and raises a protocol-error pulse in the same cycle, so the error can be traced.

Top module: `irq_mask_unit`

## Requirements
- R1: After reset every register bit is 0. Every gated line, the any-request flag, the RAM-protect output and the protocol-error output are 0.
- R2: A write with the address equal to 0xFB updates the register on the next clock edge. Bits 0 to 5 are the enables for request lines 0 to 5, bit 6 is RAM protection and bit 7 is the master enable. A write to any other address leaves the register unchanged.
- R3: When the address is 0xFB, the read data equals the current register value in the same cycle. At any other address the read data is 0.
- R4: Gated line n equals pending[n] AND enable bit n AND master bit 7. The any-request flag is the OR of the six gated lines.
- R5: The enable strobe sets bit 7 and the disable strobe clears it. When both arrive in the same cycle, the clear wins.
- R6: The interrupt-entry strobe clears bit 7. It wins over a same-cycle enable strobe or return strobe.
- R7: The interrupt-return strobe sets bit 7, unless an entry strobe or disable strobe arrives in the same cycle.
- R8: When a write to 0xFB and any of the four strobes arrive in the same cycle, the strobe decides bit 7. Bits 0 to 6 still take the written data.
- R9: With the RAM-protect option fitted, bit 6 is writable and drives the RAM-protect output. With the option not fitted, bit 6 ignores writes, reads as 0, and the output stays 0.
- R10: The protocol-error output is 1 in exactly those cycles in which a write to 0xFB occurs while bit 7 is currently 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 8 | Register address for reads and writes |
| regWrEn | input | 1 | Write strobe for the register port |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Combinational read data |
| eiStrobe | input | 1 | Enable-interrupts strobe (sets bit 7) |
| diStrobe | input | 1 | Disable-interrupts strobe (clears bit 7) |
| entryStrobe | input | 1 | Interrupt-taken strobe (clears bit 7) |
| retStrobe | input | 1 | Interrupt-return strobe (sets bit 7) |
| pendingIrq | input | 6 | Pending request inputs |
| gatedIrq | output | 6 | Masked request lines |
| anyIrq | output | 1 | OR of the gated request lines |
| ramProtEn | output | 1 | RAM-protection enable (bit 6) |
| protoErr | output | 1 | Pulse for a write made while bit 7 is set |

## Verification
The assertions check the following on every cycle:
- No gated line is active while the master bit is clear.
- Gated lines never appear without a pending request.
- Each strobe moves the master bit as required one cycle later.
- The protocol-error pulse occurs only with the master bit set.
- Bit 6 stays 0 when the option is absent.

Only the bench scenarios show the remaining behaviour:
- The same-cycle priority between strobes and writes.
- Correct full-register contents after writes to matching and non-matching addresses.
- The behaviour of a build without the option next to a build with it.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;
  // Strobes passed from the control decoder to the register datapath
  typedef struct packed {
    logic wrHit;      // register write this cycle
    logic clrMaster;  // force master bit to 0
    logic setMaster;  // force master bit to 1 (only if not cleared)
  } maskCtrl_t;
endpackage

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
  import irq_mask_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 8'hFB
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              eiStrobe,
  input  logic              diStrobe,
  input  logic              entryStrobe,
  input  logic              retStrobe,
  input  logic              masterQ,
  output maskCtrl_t         ctrl,
  output logic              rdSel,
  output logic              protoErr
);
  logic addrHit;

  always_comb begin
    addrHit        = (regAddr == MASK_ADDR);
    rdSel          = addrHit;
    ctrl.wrHit     = regWrEn && addrHit;
    // clearing sources dominate every setting source
    ctrl.clrMaster = entryStrobe || diStrobe;
    ctrl.setMaster = (eiStrobe || retStrobe) && !ctrl.clrMaster;
    protoErr       = ctrl.wrHit && masterQ;
  end
endmodule

// File: rtl/irq_mask_dp.sv
module irq_mask_dp
  import irq_mask_pkg::*;
#(
  parameter int NUM_IRQ = 6,
  parameter bit RAM_PROT_FITTED = 1'b1,
  localparam int DATA_W = NUM_IRQ + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  maskCtrl_t         ctrl,
  input  logic [DATA_W-1:0] wrData,
  input  logic [NUM_IRQ-1:0] pendingIrq,
  output logic [DATA_W-1:0] maskQ,
  output logic [NUM_IRQ-1:0] gatedIrq,
  output logic              anyIrq,
  output logic              ramProtEn
);
  localparam int PROT_BIT   = NUM_IRQ;
  localparam int MASTER_BIT = NUM_IRQ + 1;

  // per-line enable bits
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_lineEn
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           maskQ[i] <= 1'b0;
      else if (ctrl.wrHit) maskQ[i] <= wrData[i];
    end
    assign gatedIrq[i] = pendingIrq[i] & maskQ[i] & maskQ[MASTER_BIT];
  end

  // optional RAM-protect bit
  if (RAM_PROT_FITTED) begin : g_prot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           maskQ[PROT_BIT] <= 1'b0;
      else if (ctrl.wrHit) maskQ[PROT_BIT] <= wrData[PROT_BIT];
    end
  end else begin : g_noProt
    assign maskQ[PROT_BIT] = 1'b0;
    logic unusedProt;
    assign unusedProt = wrData[PROT_BIT];
  end

  // master enable: strobes first, then register write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               maskQ[MASTER_BIT] <= 1'b0;
    else if (ctrl.clrMaster) maskQ[MASTER_BIT] <= 1'b0;
    else if (ctrl.setMaster) maskQ[MASTER_BIT] <= 1'b1;
    else if (ctrl.wrHit)     maskQ[MASTER_BIT] <= wrData[MASTER_BIT];
  end

  assign anyIrq    = |gatedIrq;
  assign ramProtEn = maskQ[PROT_BIT];
endmodule

// File: rtl/irq_mask_unit.sv
module irq_mask_unit
  import irq_mask_pkg::*;
#(
  parameter int NUM_IRQ = 6,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 8'hFB,
  parameter bit RAM_PROT_FITTED = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [NUM_IRQ+1:0] regWrData,
  output logic [NUM_IRQ+1:0] regRdData,
  input  logic               eiStrobe,
  input  logic               diStrobe,
  input  logic               entryStrobe,
  input  logic               retStrobe,
  input  logic [NUM_IRQ-1:0] pendingIrq,
  output logic [NUM_IRQ-1:0] gatedIrq,
  output logic               anyIrq,
  output logic               ramProtEn,
  output logic               protoErr
);
  localparam int DATA_W = NUM_IRQ + 2;

  maskCtrl_t         ctrl;
  logic              rdSel;
  logic [DATA_W-1:0] maskQ;

  irq_mask_ctrl #(.ADDR_W(ADDR_W), .MASK_ADDR(MASK_ADDR)) u_ctrl (
    .regAddr(regAddr), .regWrEn(regWrEn), .eiStrobe(eiStrobe),
    .diStrobe(diStrobe), .entryStrobe(entryStrobe), .retStrobe(retStrobe),
    .masterQ(maskQ[DATA_W-1]), .ctrl(ctrl), .rdSel(rdSel), .protoErr(protoErr)
  );

  irq_mask_dp #(.NUM_IRQ(NUM_IRQ), .RAM_PROT_FITTED(RAM_PROT_FITTED)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .wrData(regWrData),
    .pendingIrq(pendingIrq), .maskQ(maskQ), .gatedIrq(gatedIrq),
    .anyIrq(anyIrq), .ramProtEn(ramProtEn)
  );

  assign regRdData = rdSel ? maskQ : '0;
endmodule

// File: rtl/irq_mask_checker.sv
module irq_mask_checker #(
  parameter int NUM_IRQ = 6,
  parameter bit RAM_PROT_FITTED = 1'b1,
  localparam int DATA_W = NUM_IRQ + 2
) (
  input logic               clk,
  input logic               rstN,
  input logic               eiStrobe,
  input logic               diStrobe,
  input logic               entryStrobe,
  input logic               retStrobe,
  input logic [NUM_IRQ-1:0] pendingIrq,
  input logic [NUM_IRQ-1:0] gatedIrq,
  input logic               anyIrq,
  input logic               protoErr,
  input logic [DATA_W-1:0]  maskQ
);
  localparam int MB = DATA_W - 1;

  assert_masked_when_off_R4: assert property (@(posedge clk) disable iff (!rstN)
    !maskQ[MB] |-> (gatedIrq == '0 && !anyIrq));

  assert_no_phantom_R4: assert property (@(posedge clk) disable iff (!rstN)
    (gatedIrq & ~pendingIrq) == '0);

  assert_entry_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    entryStrobe |=> !maskQ[MB]);

  assert_di_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    diStrobe |=> !maskQ[MB]);

  assert_ei_sets_R5: assert property (@(posedge clk) disable iff (!rstN)
    (eiStrobe && !diStrobe && !entryStrobe) |=> maskQ[MB]);

  assert_ret_sets_R7: assert property (@(posedge clk) disable iff (!rstN)
    (retStrobe && !diStrobe && !entryStrobe) |=> maskQ[MB]);

  assert_err_needs_master_R10: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |-> maskQ[MB]);

  assert_prot_absent_R9: assert property (@(posedge clk) disable iff (!rstN)
    !RAM_PROT_FITTED |-> !maskQ[NUM_IRQ]);
endmodule

bind irq_mask_unit irq_mask_checker #(
  .NUM_IRQ(NUM_IRQ), .RAM_PROT_FITTED(RAM_PROT_FITTED)
) u_checker (
  .clk(clk), .rstN(rstN), .eiStrobe(eiStrobe), .diStrobe(diStrobe),
  .entryStrobe(entryStrobe), .retStrobe(retStrobe), .pendingIrq(pendingIrq),
  .gatedIrq(gatedIrq), .anyIrq(anyIrq), .protoErr(protoErr), .maskQ(maskQ)
);

// File: tb/irq_mask_unit_bench.sv
module irq_mask_unit_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] regAddr = 8'h00;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic eiStrobe = 1'b0, diStrobe = 1'b0, entryStrobe = 1'b0, retStrobe = 1'b0;
  logic [5:0] pendingIrq = 6'h00;

  logic [7:0] rdA, rdB;
  logic [5:0] gA, gB;
  logic anyA, anyB, protA, protB, errA, errB;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  int refA = 0;  // model, option fitted
  int refB = 0;  // model, option absent

  always #10 clk = ~clk;  // 50 MHz

  irq_mask_unit u_irq_mask_unit (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(rdA), .eiStrobe(eiStrobe),
    .diStrobe(diStrobe), .entryStrobe(entryStrobe), .retStrobe(retStrobe),
    .pendingIrq(pendingIrq), .gatedIrq(gA), .anyIrq(anyA),
    .ramProtEn(protA), .protoErr(errA)
  );

  irq_mask_unit #(.RAM_PROT_FITTED(1'b0)) u_noProt (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(rdB), .eiStrobe(eiStrobe),
    .diStrobe(diStrobe), .entryStrobe(entryStrobe), .retStrobe(retStrobe),
    .pendingIrq(pendingIrq), .gatedIrq(gB), .anyIrq(anyB),
    .ramProtEn(protB), .protoErr(errB)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int nextMask(int cur, bit fitted);
    int n = cur;
    bit hit = regWrEn && regAddr == 8'hFB;
    if (hit) begin
      n = (n & 'h80) | (regWrData & 'h3F);
      if (fitted) n = n | (regWrData & 'h40);
    end
    if (entryStrobe || diStrobe) n = n & 'h7F;
    else if (eiStrobe || retStrobe) n = n | 'h80;
    else if (hit) n = (n & 'h7F) | (regWrData & 'h80);
    return n;
  endfunction

  task automatic checkOne(string req, int m, logic [7:0] rd, logic [5:0] g,
                          logic an, logic pr, logic er, string tag);
    int expG = (m[7]) ? (pendingIrq & m & 'h3F) : 0;
    int expRd = (regAddr == 8'hFB) ? m : 0;
    int expErr = (regWrEn && regAddr == 8'hFB && m[7]) ? 1 : 0;
    chk({req, "/R3"}, {tag, " rdData"}, rd, expRd);
    chk({req, "/R4"}, {tag, " gated"}, g, expG);
    chk({req, "/R4"}, {tag, " any"}, an, (expG != 0) ? 1 : 0);
    chk({req, "/R9"}, {tag, " ramProt"}, pr, m[6]);
    chk({req, "/R10"}, {tag, " protoErr"}, er, expErr);
  endtask

  // one cycle: inputs are already driven (after a negedge)
  task automatic step(string req);
    #2;
    checkOne(req, refA, rdA, gA, anyA, protA, errA, "fitted");
    checkOne(req, refB, rdB, gB, anyB, protB, errB, "absent");
    @(posedge clk);
    refA = nextMask(refA, 1'b1);
    refB = nextMask(refB, 1'b0);
    @(negedge clk);
    regWrEn = 0; eiStrobe = 0; diStrobe = 0; entryStrobe = 0; retStrobe = 0;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    regAddr = a; regWrEn = 1; regWrData = d;
  endtask

  initial begin
    #200000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    regAddr = 8'hFB;
    pendingIrq = 6'h3F;
    #5;
    // R1: reset state with all requests pending
    checkOne("R1", 0, rdA, gA, anyA, protA, errA, "fitted");
    checkOne("R1", 0, rdB, gB, anyB, protB, errB, "absent");
    @(negedge clk); rstN = 1;
    step("R1");
    // R2: write enables while master is off; nothing gated yet (R4)
    wr(8'hFB, 8'h7F); step("R2");
    step("R4");
    // R2: other address ignored; R3 reads 0 there
    wr(8'hFA, 8'h00); step("R2");
    regAddr = 8'hFB; step("R2");
    // R5: enable, then several pending patterns
    eiStrobe = 1; step("R5");
    pendingIrq = 6'h15; step("R4");
    pendingIrq = 6'h2A; step("R4");
    pendingIrq = 6'h00; step("R4");
    pendingIrq = 6'h3F;
    // R10: write while master set
    wr(8'hFB, 8'hC5); step("R10");
    step("R10");
    // R5: disable and enable together, clear wins
    eiStrobe = 1; diStrobe = 1; step("R5");
    step("R5");
    // R6: entry beats enable
    eiStrobe = 1; step("R6");
    entryStrobe = 1; eiStrobe = 1; step("R6");
    step("R6");
    // R7: return sets master; entry beats return
    retStrobe = 1; step("R7");
    step("R7");
    entryStrobe = 1; retStrobe = 1; step("R6");
    diStrobe = 1; retStrobe = 1; step("R7");
    step("R7");
    // R8: strobes override written bit 7
    wr(8'hFB, 8'h80); diStrobe = 1; step("R8");
    step("R8");
    wr(8'hFB, 8'h0A); eiStrobe = 1; step("R8");
    step("R8");
    wr(8'hFB, 8'h40); entryStrobe = 1; step("R8");
    step("R8");
    // R9: bit 6 write with option fitted and absent
    wr(8'hFB, 8'hFF); step("R9");
    step("R9");
    wr(8'hFB, 8'h3F); step("R9");
    step("R9");
    // R2: write bit 7 directly, then clear it by write
    wr(8'hFB, 8'h81); step("R2");
    pendingIrq = 6'h01; step("R2");
    wr(8'hFB, 8'h01); step("R2");
    step("R2");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule